// File: doc/BRIEF.md
# Data Address Watch Unit

This block watches the data accesses of a processor pipeline and raises debug events when an access address satisfies the programmed compare condition. Two 32-bit compare values, A and B, are held in configuration registers. A 2-bit mode field decides how they are used. In the exact mode each value is an independent equality watch. In the other modes the pair forms one watch: a masked bit match, an inclusive window or an exclusive window. Only event A can fire in the three paired modes.

A neighbouring instruction address comparator reports, with every data access, whether the same instruction hit its first or its third instruction watch. Two link enables can make a data event depend on that hit. A linked instruction hit is then withheld from debug status: the block's `inst1_status` and `inst3_status` outputs say whether each instruction hit may still update status. The B link only acts in the exact mode. Each comparator also has one qualifier enable from outside, which stands for privilege and address-type filtering. Without it, that comparator raises no event.

Accesses arrive as a valid/ready stream. `acc_ready` goes high in the first cycle after reset and stays high, so the block never back-pressures. An access is taken in every cycle in which `acc_valid` is high, and holding `acc_valid` low costs nothing. All outputs are registered single-cycle pulses that appear in the cycle after the access is taken. A configuration write is seen by accesses from the following cycle onward.

Top module: `data_watch_unit`

## Requirements
- R1: A synchronous active-high reset clears all event and status outputs and sets A = 0, B = 0, exact mode and both links off. An access to address 0 with both qualifiers high then raises both events.
- R2: In mode 0 (exact), event A fires when the address equals A and event B fires when it equals B, independently of each other.
- R3: In mode 1 (masked), event A fires when (address AND B) equals (A AND B), and event B never fires.
- R4: In mode 2 (inclusive), event A fires when A <= address < B, using unsigned compares, and event B never fires. When A >= B it never fires.
- R5: In mode 3 (exclusive), event A fires when address < A or address >= B, using unsigned compares, and event B never fires. When A >= B it fires for every address below A or at or above B.
- R6: An event fires only if its qualifier (`qual_a` or `qual_b`) was high with the access. The other comparator is unaffected.
- R7: With link A set, event A fires only if `ievt1` was high with the same access, and `inst1_status` stays low. With link A clear, `inst1_status` pulses for every taken access that carries `ievt1`.
- R8: With link B set in mode 0, event B fires only if `ievt3` was high, and `inst3_status` stays low. In modes 1 to 3, link B is ignored and `inst3_status` pulses for every taken access that carries `ievt3`.
- R9: Every output is a one-cycle pulse in the cycle after a taken access. Nothing fires in a cycle that follows one with `acc_valid` low.
- R10: A write with `cfg_we` high uses `cfg_sel` 0 to load A, 1 to load B and 2 to load control (mode = wdata[1:0], link A = wdata[2], link B = wdata[3]). A write with `cfg_sel` 3 changes nothing. A write affects accesses from the next cycle.
- R11: `acc_ready` is high from the first cycle after reset and never drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 = A, 1 = B, 2 = control, 3 = unused |
| cfg_wdata | input | 32 | Write data |
| acc_valid | input | 1 | Data access present |
| acc_ready | output | 1 | Always high after reset |
| acc_addr | input | 32 | Data access address |
| qual_a | input | 1 | Qualifier enable for comparator A |
| qual_b | input | 1 | Qualifier enable for comparator B |
| ievt1 | input | 1 | Instruction watch 1 hit, same instruction |
| ievt3 | input | 1 | Instruction watch 3 hit, same instruction |
| dev_a | output | 1 | Data event A pulse |
| dev_b | output | 1 | Data event B pulse |
| inst1_status | output | 1 | Instruction hit 1 may update status |
| inst3_status | output | 1 | Instruction hit 3 may update status |

## Verification
The bench places addresses on both edges of every window: equal to A, one below A, one below B and equal to B. A design that swapped a `<` for a `<=` would then raise or drop event A at exactly one of those points. It also programs A above B in both range modes, so a design that reordered the bounds would be caught. It feeds an address equal to B in the paired modes, where a design that kept event B alive would fire it. It also checks the link B suppression in exact mode against its absence in window mode, and a write to the unused select, so that misdecoding the control fields shows up as wrong status pulses or a changed mode.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  typedef enum logic [1:0] {
    CMP_EXACT   = 2'd0,
    CMP_MASKED  = 2'd1,
    CMP_INSIDE  = 2'd2,
    CMP_OUTSIDE = 2'd3
  } cmp_mode_e;

  localparam logic [1:0] SEL_CMP_A = 2'd0;
  localparam logic [1:0] SEL_CMP_B = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTRL_LINK_A_BIT = 2;
  localparam int CTRL_LINK_B_BIT = 3;

  typedef struct packed {
    cmp_mode_e mode;
    logic      link_a;
    logic      link_b;
  } watch_ctrl_t;
endpackage

// File: rtl/dwu_cfg_regs.sv
module dwu_cfg_regs
  import dwu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] cmp_a,
  output logic [AW-1:0] cmp_b,
  output watch_ctrl_t   ctrl
);
  // Write enables, one per target register
  logic [2:0] hit;
  assign hit[0] = we && (sel == SEL_CMP_A);
  assign hit[1] = we && (sel == SEL_CMP_B);
  assign hit[2] = we && (sel == SEL_CTRL);

  logic [AW-1:0] val_q [2];

  for (genvar g = 0; g < 2; g++) begin : g_cmp_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        val_q[g] <= '0;
      end else if (hit[g]) begin
        val_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl.mode   <= CMP_EXACT;
      ctrl.link_a <= 1'b0;
      ctrl.link_b <= 1'b0;
    end else if (hit[2]) begin
      ctrl.mode   <= cmp_mode_e'(wdata[1:0]);
      ctrl.link_a <= wdata[CTRL_LINK_A_BIT];
      ctrl.link_b <= wdata[CTRL_LINK_B_BIT];
    end
  end

  assign cmp_a = val_q[0];
  assign cmp_b = val_q[1];
endmodule

// File: rtl/dwu_addr_match.sv
module dwu_addr_match
  import dwu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] cmp_a,
  input  logic [AW-1:0] cmp_b,
  input  cmp_mode_e     mode,
  output logic          raw_a,
  output logic          raw_b
);
  logic [AW-1:0] ref_val [2];
  logic [1:0]    eq;

  assign ref_val[0] = cmp_a;
  assign ref_val[1] = cmp_b;

  for (genvar g = 0; g < 2; g++) begin : g_eq
    assign eq[g] = (addr == ref_val[g]);
  end

  logic masked_eq;
  logic at_or_above_a;
  logic below_b;

  assign masked_eq     = ((addr & cmp_b) == (cmp_a & cmp_b));
  assign at_or_above_a = (addr >= cmp_a);
  assign below_b       = (addr < cmp_b);

  always_comb begin
    raw_a = 1'b0;
    raw_b = 1'b0;
    unique case (mode)
      CMP_EXACT: begin
        raw_a = eq[0];
        raw_b = eq[1];
      end
      CMP_MASKED:  raw_a = masked_eq;
      CMP_INSIDE:  raw_a = at_or_above_a && below_b;
      CMP_OUTSIDE: raw_a = !at_or_above_a || !below_b;
      default: begin
        raw_a = 1'b0;
        raw_b = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/dwu_event_gate.sv
module dwu_event_gate
  import dwu_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic        raw_a,
  input  logic        raw_b,
  input  logic        qual_a,
  input  logic        qual_b,
  input  logic        ievt1,
  input  logic        ievt3,
  input  watch_ctrl_t ctrl,
  output logic        dev_a,
  output logic        dev_b,
  output logic        inst1_status,
  output logic        inst3_status
);
  // Link B only counts while the pair works as two exact watches
  logic link_b_live;
  assign link_b_live = ctrl.link_b && (ctrl.mode == CMP_EXACT);

  logic nxt_a, nxt_b, nxt_s1, nxt_s3;
  assign nxt_a  = take && qual_a && raw_a && (!ctrl.link_a || ievt1);
  assign nxt_b  = take && qual_b && raw_b && (!link_b_live || ievt3);
  assign nxt_s1 = take && ievt1 && !ctrl.link_a;
  assign nxt_s3 = take && ievt3 && !link_b_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_a        <= 1'b0;
      dev_b        <= 1'b0;
      inst1_status <= 1'b0;
      inst3_status <= 1'b0;
    end else begin
      dev_a        <= nxt_a;
      dev_b        <= nxt_b;
      inst1_status <= nxt_s1;
      inst3_status <= nxt_s3;
    end
  end
endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit
  import dwu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic          qual_a,
  input  logic          qual_b,
  input  logic          ievt1,
  input  logic          ievt3,
  output logic          dev_a,
  output logic          dev_b,
  output logic          inst1_status,
  output logic          inst3_status
);
  logic [AW-1:0] cmp_a, cmp_b;
  watch_ctrl_t   ctrl;
  logic          raw_a, raw_b;
  logic          ready_q;

  always_ff @(posedge clk) begin
    if (rst) ready_q <= 1'b0;
    else     ready_q <= 1'b1;
  end
  assign acc_ready = ready_q;

  dwu_cfg_regs #(.AW(AW)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .wdata (cfg_wdata),
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .ctrl  (ctrl)
  );

  dwu_addr_match #(.AW(AW)) u_match (
    .addr  (acc_addr),
    .cmp_a (cmp_a),
    .cmp_b (cmp_b),
    .mode  (ctrl.mode),
    .raw_a (raw_a),
    .raw_b (raw_b)
  );

  dwu_event_gate u_gate (
    .clk          (clk),
    .rst          (rst),
    .take         (acc_valid),
    .raw_a        (raw_a),
    .raw_b        (raw_b),
    .qual_a       (qual_a),
    .qual_b       (qual_b),
    .ievt1        (ievt1),
    .ievt3        (ievt3),
    .ctrl         (ctrl),
    .dev_a        (dev_a),
    .dev_b        (dev_b),
    .inst1_status (inst1_status),
    .inst3_status (inst3_status)
  );
endmodule

// File: rtl/data_watch_unit_chk.sv
module data_watch_unit_chk
  import dwu_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic [AW-1:0] acc_addr,
  input logic          qual_a,
  input logic          qual_b,
  input logic          ievt1,
  input logic          ievt3,
  input logic          dev_a,
  input logic          dev_b,
  input logic          inst1_status,
  input logic          inst3_status,
  input logic [AW-1:0] cmp_a,
  input logic [AW-1:0] cmp_b,
  input watch_ctrl_t   ctrl
);
  // R9
  dev_a_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    dev_a |-> $past(acc_valid));
  // R9
  dev_b_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    dev_b |-> $past(acc_valid));
  // R6
  dev_a_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    dev_a |-> $past(qual_a));
  // R6
  dev_b_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    dev_b |-> $past(qual_b));
  // R3
  dev_b_exact_only_chk: assert property (@(posedge clk) disable iff (rst)
    dev_b |-> ($past(ctrl.mode) == CMP_EXACT));
  // R2
  exact_b_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && qual_b && ctrl.mode == CMP_EXACT && !ctrl.link_b && acc_addr == cmp_b)
      |=> dev_b);
  // R4
  inside_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && qual_a && !ctrl.link_a && ctrl.mode == CMP_INSIDE &&
     acc_addr >= cmp_a && acc_addr < cmp_b) |=> dev_a);
  // R7
  link_a_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_a && $past(ctrl.link_a)) |-> $past(ievt1));
  // R7
  inst1_status_chk: assert property (@(posedge clk) disable iff (rst)
    inst1_status |-> $past(acc_valid && ievt1 && !ctrl.link_a));
  // R8
  inst3_status_chk: assert property (@(posedge clk) disable iff (rst)
    inst3_status |-> $past(acc_valid && ievt3 &&
                           !(ctrl.link_b && ctrl.mode == CMP_EXACT)));
  // R11
  ready_holds_chk: assert property (@(posedge clk) disable iff (rst)
    acc_ready |=> acc_ready);
endmodule

bind data_watch_unit data_watch_unit_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .acc_valid    (acc_valid),
  .acc_ready    (acc_ready),
  .acc_addr     (acc_addr),
  .qual_a       (qual_a),
  .qual_b       (qual_b),
  .ievt1        (ievt1),
  .ievt3        (ievt3),
  .dev_a        (dev_a),
  .dev_b        (dev_b),
  .inst1_status (inst1_status),
  .inst3_status (inst3_status),
  .cmp_a        (cmp_a),
  .cmp_b        (cmp_b),
  .ctrl         (ctrl)
);

// File: tb/data_watch_unit_bench.sv
`timescale 1ns/1ps
module data_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic        qual_a = 1'b0, qual_b = 1'b0, ievt1 = 1'b0, ievt3 = 1'b0;
  logic        dev_a, dev_b, inst1_status, inst3_status;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  data_watch_unit u_data_watch_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .qual_a(qual_a), .qual_b(qual_b), .ievt1(ievt1), .ievt3(ievt3),
    .dev_a(dev_a), .dev_b(dev_b), .inst1_status(inst1_status), .inst3_status(inst3_status)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    wr(2'd0, a); wr(2'd1, b); wr(2'd2, c);
  endtask

  // One access; result sampled on the next falling edge
  task automatic acc(input logic [31:0] ad, input logic qa, input logic qb,
                     input logic i1, input logic i3);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = ad; qual_a = qa; qual_b = qb; ievt1 = i1; ievt3 = i3;
    @(negedge clk);
    acc_valid = 1'b0; qual_a = 1'b0; qual_b = 1'b0; ievt1 = 1'b0; ievt3 = 1'b0;
  endtask

  task automatic acc_ab(input string req, input logic [31:0] ad, input logic ea, input logic eb);
    acc(ad, 1'b1, 1'b1, 1'b0, 1'b0);
    check(req, $sformatf("dev_a @%h", ad), dev_a, ea);
    check(req, $sformatf("dev_b @%h", ad), dev_b, eb);
  endtask

  task automatic t_reset;
    check("R1", "dev_a in reset", dev_a, 1'b0);
    check("R1", "inst1_status in reset", inst1_status, 1'b0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R11", "acc_ready after reset", acc_ready, 1'b1);
    check("R1", "dev_b idle", dev_b, 1'b0);
    acc_ab("R1", 32'h0, 1'b1, 1'b1);
    acc_ab("R1", 32'h4, 1'b0, 1'b0);
  endtask

  task automatic t_exact;
    setup(32'h1000, 32'h2000, 32'h0);
    acc_ab("R2", 32'h1000, 1'b1, 1'b0);
    acc_ab("R2", 32'h2000, 1'b0, 1'b1);
    acc_ab("R2", 32'h1001, 1'b0, 1'b0);
  endtask

  task automatic t_mask;
    setup(32'h0000_AB00, 32'h0000_FF00, 32'h1);
    acc_ab("R3", 32'h1234_AB77, 1'b1, 1'b0);
    acc_ab("R3", 32'h0000_AC00, 1'b0, 1'b0);
    acc_ab("R3", 32'h0000_FF00, 1'b0, 1'b0);
  endtask

  task automatic t_inside;
    setup(32'h100, 32'h200, 32'h2);
    acc_ab("R4", 32'h100, 1'b1, 1'b0);
    acc_ab("R4", 32'h1FF, 1'b1, 1'b0);
    acc_ab("R4", 32'h200, 1'b0, 1'b0);
    acc_ab("R4", 32'h0FF, 1'b0, 1'b0);
    wr(2'd0, 32'h300);
    acc_ab("R4", 32'h250, 1'b0, 1'b0);
    acc_ab("R4", 32'h300, 1'b0, 1'b0);
  endtask

  task automatic t_outside;
    setup(32'h100, 32'h200, 32'h3);
    acc_ab("R5", 32'h0FF, 1'b1, 1'b0);
    acc_ab("R5", 32'h100, 1'b0, 1'b0);
    acc_ab("R5", 32'h1FF, 1'b0, 1'b0);
    acc_ab("R5", 32'h200, 1'b1, 1'b0);
    acc_ab("R5", 32'hFFFF_FFFF, 1'b1, 1'b0);
    wr(2'd0, 32'h300);
    acc_ab("R5", 32'h250, 1'b1, 1'b0);
  endtask

  task automatic t_qual;
    setup(32'h40, 32'h40, 32'h0);
    acc(32'h40, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6", "dev_a with qual_a low", dev_a, 1'b0);
    check("R6", "dev_b with qual_b high", dev_b, 1'b1);
    acc(32'h40, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", "dev_a with qual_a high", dev_a, 1'b1);
    check("R6", "dev_b with qual_b low", dev_b, 1'b0);
  endtask

  task automatic t_timing;
    setup(32'h40, 32'h40, 32'h0);
    @(negedge clk);
    acc_addr = 32'h40; qual_a = 1'b1; qual_b = 1'b1; ievt1 = 1'b1; acc_valid = 1'b0;
    @(negedge clk);
    check("R9", "dev_a without valid", dev_a, 1'b0);
    check("R9", "inst1_status without valid", inst1_status, 1'b0);
    qual_a = 1'b0; qual_b = 1'b0; ievt1 = 1'b0;
    acc(32'h40, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9", "dev_a one cycle after access", dev_a, 1'b1);
    @(negedge clk);
    check("R9", "dev_a pulse ends", dev_a, 1'b0);
  endtask

  task automatic t_link_a;
    setup(32'h40, 32'h80, 32'h4);
    acc(32'h40, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R7", "linked dev_a without ievt1", dev_a, 1'b0);
    acc(32'h40, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R7", "linked dev_a with ievt1", dev_a, 1'b1);
    check("R7", "inst1_status while linked", inst1_status, 1'b0);
    wr(2'd2, 32'h0);
    acc(32'h44, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R7", "inst1_status unlinked", inst1_status, 1'b1);
  endtask

  task automatic t_link_b;
    setup(32'h80, 32'h40, 32'h8);
    acc(32'h40, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R8", "linked dev_b without ievt3", dev_b, 1'b0);
    acc(32'h40, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R8", "linked dev_b with ievt3", dev_b, 1'b1);
    check("R8", "inst3_status while linked", inst3_status, 1'b0);
    wr(2'd2, 32'hA);
    acc(32'h40, 1'b1, 1'b1, 1'b0, 1'b1);
    check("R8", "inst3_status link B in mode 2", inst3_status, 1'b1);
  endtask

  task automatic t_cfg;
    setup(32'h40, 32'h80, 32'h0);
    wr(2'd3, 32'h0000_FFFF);
    acc_ab("R10", 32'h40, 1'b1, 1'b0);
    acc_ab("R10", 32'hFFFF, 1'b0, 1'b0);
    acc(32'h44, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R10", "inst1_status after sel 3 write", inst1_status, 1'b1);
    // Write A and access in the very next cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h90;
    @(negedge clk);
    cfg_we = 1'b0;
    acc_valid = 1'b1; acc_addr = 32'h90; qual_a = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; qual_a = 1'b0;
    check("R10", "new A used next cycle", dev_a, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_exact;
        t_mask;
        t_inside;
        t_outside;
        t_qual;
        t_timing;
        t_link_a;
        t_link_b;
        t_cfg;
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule